// File: doc/BRIEF.md
# Oscillator Tuning Word Encoder with Fractional Dither

This block turns a numeric tuning word for a digitally controlled oscillator into the enable bits of its tuning elements. The word has three fields. The top field drives a coarse bank of binary-weighted cells directly. The middle field drives a fine bank of identical unit cells through a thermometer code, so each step of that field adds exactly one enabled unit. The bottom fractional field feeds a first-order sigma-delta accumulator. The carry of that accumulator switches one extra unit cell on and off. Its time average places the effective tuning value between two unit steps.

A frequency-acquisition or tracking loop presents a new word with a one-cycle strobe. The block runs on the dither clock, which is much faster than the rate at which new words arrive. A captured word stays in force until the next strobe. The accumulator residue carries over from one word to the next, so no fractional error is lost at a word change.

Top module: `dco_tune_enc`

## Requirements
- R1: While reset is low and on the first sample after it is released, coarse_o, therm_o and dither_o are all zero.
- R2: On a clock edge with word_valid_i high, the word is captured. From that edge on, coarse_o equals word_i[18:13], the fine field is word_i[12:8] and the fractional field is word_i[7:0].
- R3: On a clock edge with word_valid_i low, the word input is ignored and coarse_o and therm_o keep their values.
- R4: For a fine field value f, therm_o has bits 0 to f-1 set and every other bit clear, so its population count equals f.
- R5: Raising the fine field by one sets exactly one additional therm_o bit and clears none.
- R6: With a fractional field k held over 256 consecutive dither cycles, dither_o is high in exactly k of them. The count starts with the edge after the capture edge.
- R7: While the captured fractional field is zero, dither_o stays low.
- R8: dither_o after each edge is the carry out of adding the fractional field in force before that edge to an 8-bit accumulator. The accumulator keeps its remainder across word captures and starts from zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dither clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Capture strobe for word_i |
| word_i | input | 19 | Tuning word: coarse, fine integer and fraction |
| coarse_o | output | 6 | Binary-weighted coarse bank enables |
| therm_o | output | 31 | Thermometer enables for the fine unit bank |
| dither_o | output | 1 | Enable of the extra dithered unit cell |

## Verification
The assertions assume that word_valid_i and word_i are clean at every dither clock edge. They relate each capture, or each absence of one, to the outputs one edge later. The bench drives all inputs just after a rising edge and samples outputs one nanosecond after the next edge. Directed runs hold one fraction for exactly 256 cycles with no capture in between. The random phase changes the word at irregular intervals, so the carried-over remainder is exercised against a bench-side accumulator model.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;
  parameter int unsigned DEF_CRS_W  = 6;
  parameter int unsigned DEF_FINE_W = 5;
  parameter int unsigned DEF_FRAC_W = 8;
endpackage

// File: rtl/dco_word_reg.sv
module dco_word_reg #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dco_therm_dec.sv
module dco_therm_dec #(
  parameter int unsigned FINE_W = 5,
  localparam int unsigned THERM_W = (1 << FINE_W) - 1
) (
  input  logic [FINE_W-1:0]  fine_i,
  output logic [THERM_W-1:0] therm_o
);
  for (genvar g = 0; g < THERM_W; g++) begin : g_cell
    assign therm_o[g] = (fine_i > FINE_W'(g));
  end
endmodule

// File: rtl/dco_sd_mod.sv
module dco_sd_mod #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              dither_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  // residue is kept across word updates; only reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      dither_o <= 1'b0;
    end else begin
      acc_q    <= sum[FRAC_W-1:0];
      dither_o <= sum[FRAC_W];
    end
  end
endmodule

// File: rtl/dco_tune_enc.sv
module dco_tune_enc
  import dco_enc_pkg::*;
#(
  parameter int unsigned CRS_W  = DEF_CRS_W,
  parameter int unsigned FINE_W = DEF_FINE_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W  = CRS_W + FINE_W + FRAC_W,
  localparam int unsigned THERM_W = (1 << FINE_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [CRS_W-1:0]   coarse_o,
  output logic [THERM_W-1:0] therm_o,
  output logic               dither_o
);
  logic [WORD_W-1:0] word_q;
  logic [FINE_W-1:0] fine_q;
  logic [FRAC_W-1:0] frac_q;

  dco_word_reg #(.W(WORD_W)) u_word (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(word_valid_i),
    .d_i   (word_i),
    .q_o   (word_q)
  );

  assign coarse_o = word_q[WORD_W-1 -: CRS_W];
  assign fine_q   = word_q[FRAC_W +: FINE_W];
  assign frac_q   = word_q[FRAC_W-1:0];

  dco_therm_dec #(.FINE_W(FINE_W)) u_therm (
    .fine_i (fine_q),
    .therm_o(therm_o)
  );

  dco_sd_mod #(.FRAC_W(FRAC_W)) u_sd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frac_i  (frac_q),
    .dither_o(dither_o)
  );
endmodule

// File: rtl/dco_tune_enc_chk.sv
module dco_tune_enc_chk #(
  parameter int unsigned CRS_W  = 6,
  parameter int unsigned FINE_W = 5,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned WORD_W  = CRS_W + FINE_W + FRAC_W,
  localparam int unsigned THERM_W = (1 << FINE_W) - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               word_valid_i,
  input logic [WORD_W-1:0]  word_i,
  input logic [CRS_W-1:0]   coarse_o,
  input logic [THERM_W-1:0] therm_o,
  input logic               dither_o,
  input logic [FRAC_W-1:0]  frac_q
);
  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |=> coarse_o == $past(word_i[WORD_W-1 -: CRS_W]));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> $stable(coarse_o) && $stable(therm_o));

  assert_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |=> $countones(therm_o) == int'($past(word_i[FRAC_W +: FINE_W])));

  assert_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o & (therm_o + THERM_W'(1))) == '0);

  assert_zero_frac_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_q == '0 |=> !dither_o);
endmodule

bind dco_tune_enc dco_tune_enc_chk #(
  .CRS_W (CRS_W),
  .FINE_W(FINE_W),
  .FRAC_W(FRAC_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_valid_i(word_valid_i),
  .word_i      (word_i),
  .coarse_o    (coarse_o),
  .therm_o     (therm_o),
  .dither_o    (dither_o),
  .frac_q      (frac_q)
);

// File: tb/dco_tune_enc_tb.sv
module dco_tune_enc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [18:0] word = '0;
  logic [5:0]  coarse;
  logic [30:0] therm;
  logic        dith;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  // bench model
  logic [5:0] m_crs = '0;
  logic [4:0] m_fine = '0;
  logic [7:0] m_frac = '0;
  logic [7:0] m_acc = '0;
  logic       m_dith = 1'b0;

  always #2 clk = ~clk;

  dco_tune_enc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_i(word),
    .coarse_o(coarse), .therm_o(therm), .dither_o(dith)
  );

  function automatic logic [30:0] therm_of(input logic [4:0] f);
    logic [31:0] t;
    t = (32'd1 << f) - 32'd1;
    return t[30:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(coarse == m_crs, "R2 coarse", coarse, m_crs);
    chk(therm == therm_of(m_fine), "R4 therm", therm, therm_of(m_fine));
    chk(dith == m_dith, "R8 dither", dith, m_dith);
  endtask

  // one dither cycle: drive, edge, update model, sample
  task automatic cyc(input bit v, input logic [18:0] w);
    logic [8:0] s;
    vld  = v;
    word = w;
    @(posedge clk);
    s      = {1'b0, m_acc} + {1'b0, m_frac};
    m_acc  = s[7:0];
    m_dith = s[8];
    if (v) begin
      m_crs  = w[18:13];
      m_fine = w[12:8];
      m_frac = w[7:0];
    end
    #1;
    compare_all();
  endtask

  task automatic frac_run(input logic [7:0] k);
    int cnt;
    cyc(1'b1, {6'h2a, 5'd9, k});
    cnt = 0;
    for (int i = 0; i < 256; i++) begin
      cyc(1'b0, 19'($urandom));
      if (dith) cnt++;
    end
    chk(cnt == int'(k), "R6 dither count", cnt, k);
    if (k == 0) chk(cnt == 0, "R7 zero fraction", cnt, 0);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(coarse == 0 && therm == 0 && dith == 0, "R1 in reset", {coarse, therm, dith}, 0);
    #10;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(coarse == 0 && therm == 0 && dith == 0, "R1 after release", {coarse, therm, dith}, 0);

    // R2/R3: capture only with strobe
    cyc(1'b1, {6'h3f, 5'd31, 8'h00});
    chk(coarse == 6'h3f, "R2 capture", coarse, 6'h3f);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 19'($urandom));
      chk(coarse == 6'h3f && therm == therm_of(5'd31), "R3 held", therm, therm_of(5'd31));
    end
    chk(dith == 1'b0, "R7 zero fraction after hold", dith, 0);

    // R5: monotonic fine sweep
    for (int f = 0; f < 32; f++) begin
      logic [30:0] prev;
      prev = therm;
      cyc(1'b1, {6'h01, 5'(f), 8'h00});
      chk($countones(therm) == f, "R4 population", $countones(therm), f);
      if (f > 0)
        chk(((therm & prev) == prev) && ($countones(therm) == $countones(prev) + 1),
            "R5 one more unit", therm, prev);
    end

    // R6 directed fractions
    frac_run(8'd0);
    frac_run(8'd1);
    frac_run(8'd128);
    frac_run(8'd255);
    frac_run(8'd77);

    // random words with irregular strobes; R8 residue across updates
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 5) == 0, 19'($urandom));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule